// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block is the software-visible side of one PS/2 keyboard or mouse port. A host reaches it through a simple word-addressed bus with separate read and write strobes, a 12-bit byte offset and 32-bit data. Read data is combinational and valid in the same cycle as the read strobe. Writes take effect at the clock edge that ends the strobe cycle.

On the device side, a serial engine (not part of this block) delivers received bytes through a valid/ready byte input. The block holds one such byte and marks it pending until the host reads it. Bytes the host writes to the data register leave on a one-cycle valid byte output.

The block holds a control word, a clock-divisor word and the last byte the host has read. It also exposes a status word, an interrupt-identification word, a constant identification window at the top of its address space, a registered interrupt line and a one-cycle flag for accesses to offsets that have no meaning.

Top module: `ps2_port_regs`

## Requirements
- R1: Word index = offset[11:2]. Index 0 is control and index 3 is clock divisor. Both store the full 32-bit written value and read it back. Reset (synchronous, active low) clears control, divisor, the last-read byte and the pending flag to zero.
- R2: Reads at offsets 0xFE0..0xFFC return one identification byte per word in bits [7:0], upper bits zero, in the order 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R3: Reading index 1 (status) returns the following bits:
  - bit 6 = 1 (transmit empty);
  - bit 4 = the pending flag;
  - bit 2 = XOR of all 8 bits of the last-read byte;
  - bits 5, 3, 1, 0 and all bits above 6 = 0.
- R4: A read of index 2 (data) returns the held byte and makes it the last-read byte when a byte is pending. When no byte is pending, it returns the last-read byte again and changes nothing.
- R5: rx_ready is high when no byte is pending or when a data read is present in that cycle. A byte is accepted when rx_valid and rx_ready are both high, and acceptance sets pending. A consuming data read clears pending unless a new byte is accepted in the same cycle, in which case pending stays set.
- R6: irq is registered. One cycle after each clock edge, it equals ((pending AND control bit 4) OR control bit 3) as those stood before that edge.
- R7: Reading index 4 returns bit 1 = 1, bit 0 = pending, and all other bits 0.
- R8: A write to index 2 pulses tx_valid for exactly one cycle after the write edge, with tx_data = bits [7:0] of the written value. tx_valid is otherwise low.
- R9: Reads of indices 5..1015 return zero. Writes to any index other than 0, 2 and 3 change no state. Either kind of access raises addr_err for exactly the one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as bus_rd, zero otherwise |
| rx_valid | input | 1 | Device offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block can take a byte this cycle |
| tx_valid | output | 1 | One-cycle pulse carrying a host-written byte |
| tx_data | output | 8 | Byte written by the host |
| irq | output | 1 | Registered interrupt request |
| addr_err | output | 1 | One-cycle flag after an access to an undefined offset |

## Verification
The bench targets data reads with nothing pending. A design that fetched anyway would return the stale held byte and flip status parity. It also targets a byte arriving in the same cycle as a consuming read: a design that cleared pending there would lose that byte, and the next data read would return the old value with receive-full low. Control words with only bit 3 or only bit 4 set probe the two interrupt terms separately, where a design that gated both terms by pending would hold irq low. Writes to status, interrupt identification and the identification window are followed by control and divisor reads, which expose any decode that lets such a write land in a real register.

// File: rtl/ps2r_pkg.sv
// Package: shared constants, select type and identification bytes for the
// PS/2 port register front end. Assumes a 32-bit bus, word-indexed offsets.
package ps2r_pkg;

    localparam logic [9:0] IDX_CTRL = 10'd0;
    localparam logic [9:0] IDX_STAT = 10'd1;
    localparam logic [9:0] IDX_DATA = 10'd2;
    localparam logic [9:0] IDX_DIV  = 10'd3;
    localparam logic [9:0] IDX_IIR  = 10'd4;

    localparam int ST_TX_EMPTY = 6;
    localparam int ST_RX_FULL  = 4;
    localparam int ST_PARITY   = 2;

    localparam int CTRL_RX_IE  = 4;
    localparam int CTRL_TX_IE  = 3;

    // One-hot-style select bundle from the address decoder.
    typedef struct packed {
        logic ctrl;
        logic stat;
        logic data;
        logic div;
        logic iir;
        logic idwin;
        logic bad_rd;
        logic bad_wr;
    } ps2r_sel_t;

    // Identification byte for word n of the constant window.
    function automatic logic [7:0] id_byte(input logic [2:0] n);
        case (n)
            3'd0:    id_byte = 8'h50;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/ps2r_decode.sv
// Module: address decoder. Turns a byte offset into register selects.
// Assumes the identification window is the top eight words of the space.
// Read and write legality differ: status, IIR and ID words are read-only.
module ps2r_decode
    import ps2r_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output ps2r_sel_t         sel
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'((1 << ADDR_W) - 32);

    logic [IDX_W-1:0] idx;
    logic             known_rd;

    // Purpose: classify the offset into one register or an undefined slot.
    always_comb begin
        idx       = addr[ADDR_W-1:2];
        sel.idwin = (addr >= ID_BASE);
        sel.ctrl  = !sel.idwin && (idx == IDX_W'(IDX_CTRL));
        sel.stat  = !sel.idwin && (idx == IDX_W'(IDX_STAT));
        sel.data  = !sel.idwin && (idx == IDX_W'(IDX_DATA));
        sel.div   = !sel.idwin && (idx == IDX_W'(IDX_DIV));
        sel.iir   = !sel.idwin && (idx == IDX_W'(IDX_IIR));
        known_rd  = sel.ctrl | sel.stat | sel.data | sel.div | sel.iir | sel.idwin;
        sel.bad_rd = !known_rd;
        sel.bad_wr = !(sel.ctrl | sel.data | sel.div);
    end

    // R9: a write-legal offset is always a read-legal one
    always_comb begin
        assert (!(sel.bad_rd && !sel.bad_wr));
    end

endmodule

// File: rtl/ps2r_rx_path.sv
// Module: receive holding path. Keeps one pending byte from the device and
// the last byte handed to the host. Assumes the host read strobe for the
// data register arrives as rd_data and is a single-cycle event.
module ps2r_rx_path #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rd_data,
    output logic              rx_ready,
    output logic              pending,
    output logic [BYTE_W-1:0] held,
    output logic [BYTE_W-1:0] last
);
    logic consume;
    logic accept;

    // Purpose: handshake and consume qualifiers.
    always_comb begin
        consume  = rd_data && pending;
        rx_ready = !pending || rd_data;
        accept   = rx_valid && rx_ready;
    end

    // Purpose: pending flag, held byte and last-read byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            held    <= '0;
            last    <= '0;
        end else begin
            if (consume) last <= held;
            if (accept)  held <= rx_data;
            if (accept)       pending <= 1'b1;
            else if (consume) pending <= 1'b0;
        end
    end

    // R5: an accepted byte is pending on the next cycle
    a_r5_accept_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> pending);

    // R5: a consuming read with no new byte empties the holder
    a_r5_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && pending && !rx_valid) |=> !pending);

    // R4: a data read with nothing pending leaves the last byte alone
    a_r4_idle_read_keeps_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !pending) |=> $stable(last));

endmodule

// File: rtl/ps2_port_regs.sv
// Module: PS/2 port register front end (top). Holds control and divisor
// words, builds status and interrupt words, forwards host bytes to the
// device side and drives a registered interrupt. Assumes at most one of
// bus_rd / bus_wr per cycle; read data is combinational.
module ps2_port_regs
    import ps2r_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq,
    output logic              addr_err
);
    ps2r_sel_t         sel;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] div_q;
    logic              pending;
    logic [BYTE_W-1:0] held;
    logic [BYTE_W-1:0] last;
    logic [DATA_W-1:0] stat_word;

    ps2r_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    ps2r_rx_path #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rd_data  (bus_rd && sel.data),
        .rx_ready (rx_ready),
        .pending  (pending),
        .held     (held),
        .last     (last)
    );

    // Purpose: store control and divisor words on host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else if (bus_wr) begin
            if (sel.ctrl) ctrl_q <= bus_wdata;
            if (sel.div)  div_q  <= bus_wdata;
        end
    end

    // Purpose: assemble the status word.
    always_comb begin
        stat_word = '0;
        stat_word[ST_TX_EMPTY] = 1'b1;
        stat_word[ST_RX_FULL]  = pending;
        stat_word[ST_PARITY]   = ^last;
    end

    // Purpose: read data multiplexer, zero when idle or undefined.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel.idwin)     bus_rdata = DATA_W'(id_byte(bus_addr[4:2]));
            else if (sel.ctrl) bus_rdata = ctrl_q;
            else if (sel.stat) bus_rdata = stat_word;
            else if (sel.data) bus_rdata = DATA_W'(pending ? held : last);
            else if (sel.div)  bus_rdata = div_q;
            else if (sel.iir)  bus_rdata = DATA_W'({1'b1, pending});
        end
    end

    // Purpose: registered interrupt, error pulse and transmit byte pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            addr_err <= 1'b0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            irq      <= (pending && ctrl_q[CTRL_RX_IE]) || ctrl_q[CTRL_TX_IE];
            addr_err <= (bus_rd && sel.bad_rd) || (bus_wr && sel.bad_wr);
            tx_valid <= bus_wr && sel.data;
            if (bus_wr && sel.data) tx_data <= bus_wdata[BYTE_W-1:0];
        end
    end

    // R6: interrupt follows the pending/control terms one cycle later
    a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past((pending && ctrl_q[CTRL_RX_IE]) || ctrl_q[CTRL_TX_IE]));

    // R8: a data write emits its low byte on the next cycle
    a_r8_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel.data) |=> (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0])));

    // R8: the transmit pulse never lasts two cycles
    a_r8_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !$past(bus_wr)) |-> 1'b0 || !tx_valid);

    // R9: an undefined read raises the error flag on the next cycle
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel.bad_rd) |=> addr_err);

    // R3: status always reports transmit empty
    a_r3_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel.stat) |-> bus_rdata[ST_TX_EMPTY]);

    // R9: undefined reads return zero
    a_r9_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel.bad_rd) |-> (bus_rdata == '0));

endmodule

// File: tb/ps2_port_regs_bench.sv
// Bench: fixed-seed random bus and device traffic mixed with directed
// corner cases; a bench-side model predicts every observed value.
module ps2_port_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq, addr_err;
    logic [7:0]  tx_data;

    int total = 0;
    int bad = 0;

    // model state
    logic        pm = 1'b0;
    logic [7:0]  hm = '0, lm = '0;
    logic [31:0] cm = '0, dm = '0;

    always #10 clk = ~clk;

    ps2_port_regs u_ps2_port_regs (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq), .addr_err(addr_err)
    );

    function automatic logic [7:0] idv(input int n);
        logic [63:0] t = 64'h50_10_04_00_0D_F0_05_B1;
        return t[63 - 8*n -: 8];
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        int i = int'(a[11:2]);
        if (a >= 12'hFE0) return {24'b0, idv(i - 1016)};
        case (i)
            0: return cm;
            1: return {25'b0, 1'b1, 1'b0, pm, 1'b0, ^lm, 2'b0};
            2: return {24'b0, pm ? hm : lm};
            3: return dm;
            4: return {30'b0, 1'b1, pm};
            default: return 32'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        int i = int'(a[11:2]);
        if (a >= 12'hFE0) return "R2";
        case (i)
            0, 3: return "R1";
            1: return "R3";
            2: return "R4";
            4: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus/device cycle, checked against the model.
    task automatic cyc(input logic rd, input logic wr, input logic [11:0] a,
                       input logic [31:0] wd, input logic rxv, input logic [7:0] rxd);
        int i = int'(a[11:2]);
        logic ei, cons, acc, et, ee, rdu, wru;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        rx_valid = rxv; rx_data = rxd;
        #2;
        if (rd) chk(tag_of(a), bus_rdata, exp_rd(a));
        chk("R5 rx_ready", {31'b0, rx_ready}, {31'b0, (!pm || (rd && i == 2 && a < 12'hFE0))});
        rdu = (a < 12'hFE0) && (i > 4);
        wru = (a >= 12'hFE0) || !(i == 0 || i == 2 || i == 3);
        ei = (pm && cm[4]) || cm[3];
        cons = rd && i == 2 && a < 12'hFE0 && pm;
        acc = rxv && (!pm || (rd && i == 2 && a < 12'hFE0));
        et = wr && i == 2 && a < 12'hFE0;
        ee = (rd && rdu) || (wr && wru);
        if (cons) lm = hm;
        if (acc) hm = rxd;
        if (acc) pm = 1'b1; else if (cons) pm = 1'b0;
        if (wr && a < 12'hFE0 && i == 0) cm = wd;
        if (wr && a < 12'hFE0 && i == 3) dm = wd;
        @(posedge clk); #2;
        chk("R6 irq", {31'b0, irq}, {31'b0, ei});
        chk("R8 tx_valid", {31'b0, tx_valid}, {31'b0, et});
        if (et) chk("R8 tx_data", {24'b0, tx_data}, {24'b0, wd[7:0]});
        chk("R9 addr_err", {31'b0, addr_err}, {31'b0, ee});
        bus_rd = 0; bus_wr = 0; rx_valid = 0;
    endtask

    task automatic rd_(input logic [11:0] a); cyc(1, 0, a, 0, 0, 0); endtask
    task automatic wr_(input logic [11:0] a, input logic [31:0] d); cyc(0, 1, a, d, 0, 0); endtask

    initial begin
        void'($urandom(32'h1D5EED));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state, R3/R7 idle words
        rd_(12'h000); rd_(12'h00C); rd_(12'h004); rd_(12'h010);
        // R2 identification window
        for (int k = 0; k < 8; k++) rd_(12'hFE0 + 12'(4 * k));
        // R4 data read with nothing pending returns last (zero)
        rd_(12'h008);
        // R5 push a byte, R3 receive full and parity, R4 consume then repeat
        cyc(0, 0, 12'h000, 0, 1, 8'h07);
        rd_(12'h004); rd_(12'h010);
        rd_(12'h008); rd_(12'h008); rd_(12'h004);
        // R5 byte arriving with a consuming read keeps pending
        cyc(0, 0, 12'h000, 0, 1, 8'hA5);
        cyc(1, 0, 12'h008, 0, 1, 8'h3C);
        rd_(12'h004); rd_(12'h008); rd_(12'h008);
        // R6 each interrupt term alone
        wr_(12'h000, 32'h0000_0008); rd_(12'h000);
        wr_(12'h000, 32'h0000_0010); rd_(12'h000);
        cyc(0, 0, 12'h000, 0, 1, 8'h11); rd_(12'h000); rd_(12'h008); rd_(12'h000);
        // R8 data write forwards the low byte
        wr_(12'h008, 32'hDEAD_BE5A);
        // R9 writes to read-only and undefined offsets change nothing
        wr_(12'h00C, 32'h1234_5678);
        wr_(12'h004, 32'hFFFF_FFFF); wr_(12'h010, 32'hFFFF_FFFF);
        wr_(12'hFE4, 32'hFFFF_FFFF); wr_(12'h400, 32'hFFFF_FFFF);
        rd_(12'h000); rd_(12'h00C); rd_(12'h014); rd_(12'hFDC);
        // random mix
        for (int n = 0; n < 4000; n++) begin
            int op = int'($urandom % 10);
            logic rxv = 1'($urandom);
            logic [7:0] rxd = 8'($urandom);
            logic [31:0] w = $urandom;
            logic [11:0] ua = 12'(20 + 4 * ($urandom % 1011));
            case (op)
                0, 1: cyc(1, 0, 12'h008, 0, rxv, rxd);
                2: cyc(1, 0, 12'h004, 0, rxv, rxd);
                3: cyc(1, 0, 12'h010, 0, rxv, rxd);
                4: cyc(0, 1, 12'h000, w & 32'h0000_0018 | (w & 32'hFFFF_FF00), rxv, rxd);
                5: cyc(0, 1, 12'h00C, w, rxv, rxd);
                6: cyc(0, 1, 12'h008, w, rxv, rxd);
                7: cyc(1, 0, ($urandom % 2) ? 12'h000 : 12'h00C, 0, rxv, rxd);
                8: cyc($urandom % 2 == 0, 0, ua, 0, rxv, rxd);
                default: cyc(0, 1, ua, w, rxv, rxd);
            endcase
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4_000_000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule